// File: doc/BRIEF.md
# Temperature Window Comparator

This block watches the stream of averaged 12-bit conversion results from a temperature sensor's conversion sequencer. It checks each result against a lower and an upper limit code. A result outside the band between them sets a sticky compare flag. The flag stays set until software clears it. A separate mask bit decides whether the flag drives the interrupt line. The block does not sequence the converter and does not turn codes into degrees.

Software sets up the block through a small register port. It writes the two limits, turns comparison on and unmasks the interrupt. When the interrupt fires, software reads the status register, clears the flag by writing a one to the clear register, and then programs a new band. The results arrive as a single-cycle valid strobe with a 12-bit code. Only averaged results are sent to this input.

Top module: `therm_window_cmp`

## Requirements
- R1: After synchronous reset, the enable, mask, both limits and the compare flag all read zero, and `cmp_irq` is low.
- R2: Registers sit at these byte offsets: control at 0x18 (bit 0 = compare enable), lower limit at 0x1C (bits 11:0), upper limit at 0x20 (bits 11:0), status at 0x30 (bit 1 = compare flag), mask at 0x34 (bit 1 = interrupt unmask) and clear at 0x38 (bit 1). A limit write keeps only bits 11:0, and bits above 11 read as zero. The clear offset and any unmapped offset read as zero.
- R3: The flag is set in the cycle after a cycle in which `res_valid` is high, comparison is enabled and `res_code` is strictly below the lower limit or strictly above the upper limit. A code equal to either limit does not set the flag. A code presented while `res_valid` is low does not set the flag.
- R4: Writing a word with bit 1 set to offset 0x38 clears the flag on the next cycle. Writing to 0x38 with bit 1 clear has no effect. Writing to the status offset has no effect.
- R5: While bit 0 of the control register is zero, results never set the flag. A flag that is already set stays set until it is cleared.
- R6: `cmp_irq` is a register loaded each cycle with the flag AND the mask bit, so it follows a change in either one with one cycle of lag.
- R7: If a set event and a clear write happen in the same cycle, the flag ends up set.
- R8: While the lower limit is not strictly below the upper limit, the window is invalid and no result sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| res_valid | input | 1 | One-cycle strobe marking an averaged result |
| res_code | input | 12 | Averaged conversion code |
| cmp_irq | output | 1 | Registered compare interrupt |

## Verification
The comparison is tried with codes well inside the band, codes equal to each limit, and codes one step below the lower limit and one step above the upper limit. These patterns separate strict comparisons from inclusive ones, and separate a check on the low side from a check on the high side. Further patterns feed an out-of-range code with the valid strobe low, with comparison disabled, and with a degenerate or inverted window. Each of these must leave the flag clear, which shows that every gating condition is needed. A clear write in the same cycle as an out-of-range result shows that set wins over clear. Reading `cmp_irq` one cycle before and one cycle after a mask or flag change shows the register stage on the interrupt.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int CODE_W = 12;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LO   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_HI   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h38;

    localparam int BIT_EN  = 0;
    localparam int BIT_CMP = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LO,
        SEL_HI,
        SEL_STAT,
        SEL_MASK,
        SEL_CLR
    } twc_sel_e;

    typedef struct packed {
        logic              enable;
        logic              unmask;
        logic [CODE_W-1:0] lo;
        logic [CODE_W-1:0] hi;
    } twc_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } twc_sample_t;

    function automatic twc_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        twc_sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_LO:   s = SEL_LO;
            OFS_HI:   s = SEL_HI;
            OFS_STAT: s = SEL_STAT;
            OFS_MASK: s = SEL_MASK;
            OFS_CLR:  s = SEL_CLR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic window_ok(input logic [CODE_W-1:0] lo,
                                       input logic [CODE_W-1:0] hi);
        return lo < hi;
    endfunction

    function automatic logic outside(input logic [CODE_W-1:0] code,
                                     input logic [CODE_W-1:0] lo,
                                     input logic [CODE_W-1:0] hi);
        return (code < lo) || (code > hi);
    endfunction

endpackage

// File: rtl/twc_regfile.sv
module twc_regfile
    import twc_pkg::*;
#(
    parameter int AW = twc_pkg::ADDR_W,
    parameter int DW = twc_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          flag,
    output twc_cfg_t      cfg,
    output logic          clr_pulse,
    output logic [DW-1:0] rdata
);

    twc_sel_e sel;
    twc_cfg_t cfg_q;

    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_CTRL: cfg_q.enable <= wdata[BIT_EN];
                SEL_LO:   cfg_q.lo     <= wdata[CODE_W-1:0];
                SEL_HI:   cfg_q.hi     <= wdata[CODE_W-1:0];
                SEL_MASK: cfg_q.unmask <= wdata[BIT_CMP];
                default:  ;
            endcase
        end
    end

    assign clr_pulse = we && (sel == SEL_CLR) && wdata[BIT_CMP];
    assign cfg       = cfg_q;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: rdata[BIT_EN]       = cfg_q.enable;
            SEL_LO:   rdata[CODE_W-1:0]   = cfg_q.lo;
            SEL_HI:   rdata[CODE_W-1:0]   = cfg_q.hi;
            SEL_STAT: rdata[BIT_CMP]      = flag;
            SEL_MASK: rdata[BIT_CMP]      = cfg_q.unmask;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/twc_window.sv
module twc_window
    import twc_pkg::*;
(
    input  twc_cfg_t    cfg,
    input  twc_sample_t smp,
    output logic        hit
);

    logic band_ok;
    logic off_band;

    assign band_ok  = window_ok(cfg.lo, cfg.hi);
    assign off_band = outside(smp.code, cfg.lo, cfg.hi);
    assign hit      = smp.valid && cfg.enable && band_ok && off_band;

endmodule

// File: rtl/twc_flag.sv
module twc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic unmask,
    output logic flag_q,
    output logic irq_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= set_evt | (flag_q & ~clr_evt);
            irq_q  <= flag_q & unmask;
        end
    end

endmodule

// File: rtl/therm_window_cmp.sv
module therm_window_cmp
    import twc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                res_valid,
    input  logic [CODE_W-1:0]   res_code,
    output logic                cmp_irq
);

    twc_cfg_t          cfg;
    twc_sample_t       smp;
    logic              clr_pulse;
    logic              hit;
    logic              cmp_flag;
    logic              cfg_en;
    logic              cfg_unmask;
    logic [CODE_W-1:0] cfg_lo;
    logic [CODE_W-1:0] cfg_hi;

    assign smp.valid  = res_valid;
    assign smp.code   = res_code;
    assign cfg_en     = cfg.enable;
    assign cfg_unmask = cfg.unmask;
    assign cfg_lo     = cfg.lo;
    assign cfg_hi     = cfg.hi;

    twc_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .flag      (cmp_flag),
        .cfg       (cfg),
        .clr_pulse (clr_pulse),
        .rdata     (reg_rdata)
    );

    twc_window u_win (
        .cfg (cfg),
        .smp (smp),
        .hit (hit)
    );

    twc_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (hit),
        .clr_evt (clr_pulse),
        .unmask  (cfg_unmask),
        .flag_q  (cmp_flag),
        .irq_q   (cmp_irq)
    );

endmodule

// File: rtl/twc_chk.sv
module twc_chk
    import twc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              res_valid,
    input logic [CODE_W-1:0] res_code,
    input logic              cmp_irq,
    input logic              flag_q,
    input logic              en_q,
    input logic              unmask_q,
    input logic [CODE_W-1:0] lo_q,
    input logic [CODE_W-1:0] hi_q
);

    logic clr_wr;
    assign clr_wr = reg_we && (reg_addr == OFS_CLR) && reg_wdata[BIT_CMP];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!cmp_irq && !flag_q));

    // R3
    below_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && en_q && (lo_q < hi_q) && (res_code < lo_q)) |=> flag_q);

    // R3
    above_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && en_q && (lo_q < hi_q) && (res_code > hi_q)) |=> flag_q);

    // R4
    clear_works_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !res_valid) |=> !flag_q);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !flag_q) |=> !flag_q);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_wr) |=> flag_q);

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && unmask_q) |=> cmp_irq);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_irq) |-> ($past(flag_q) && $past(unmask_q)));

    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && res_valid && en_q && (lo_q < hi_q) && (res_code > hi_q)) |=> flag_q);

    // R8
    bad_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!(lo_q < hi_q) && !flag_q) |=> !flag_q);

endmodule

bind therm_window_cmp twc_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .res_valid (res_valid),
    .res_code  (res_code),
    .cmp_irq   (cmp_irq),
    .flag_q    (cmp_flag),
    .en_q      (cfg_en),
    .unmask_q  (cfg_unmask),
    .lo_q      (cfg_lo),
    .hi_q      (cfg_hi)
);

// File: tb/therm_window_cmp_test.sv
`timescale 1ns/1ps
module therm_window_cmp_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        res_valid = 1'b0;
    logic [11:0] res_code = 12'h0;
    logic        cmp_irq;

    always #2 clk = ~clk;

    therm_window_cmp uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .res_valid (res_valid),
        .res_code  (res_code),
        .cmp_irq   (cmp_irq)
    );

    localparam logic [7:0] A_CTRL = 8'h18, A_LO = 8'h1C, A_HI = 8'h20,
                           A_STAT = 8'h30, A_MASK = 8'h34, A_CLR = 8'h38;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] val;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    // monitor: pops the oldest expectation and compares it with the design
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [31:0] act;
                e = sb_q.pop_front();
                act = e.is_irq ? {31'b0, cmp_irq} : reg_rdata;
                vectors++;
                if (act !== e.val) begin
                    miscompares++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.val);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic feed(input logic [11:0] c);
        @(negedge clk);
        res_valid = 1'b1; res_code = c;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic exp_reg(input string tag, input logic [7:0] a, input logic [31:0] v);
        exp_t e;
        e.tag = tag; e.is_irq = 1'b0; e.val = v;
        reg_addr = a;
        sb_q.push_back(e);
        #1;
        ->mon_ev;
        #0;
    endtask

    task automatic exp_irq(input string tag, input logic v);
        exp_t e;
        e.tag = tag; e.is_irq = 1'b1; e.val = {31'b0, v};
        sb_q.push_back(e);
        #1;
        ->mon_ev;
        #0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        exp_reg("R1 status", A_STAT, 32'h0);
        exp_reg("R1 control", A_CTRL, 32'h0);
        exp_reg("R1 lower", A_LO, 32'h0);
        exp_reg("R1 upper", A_HI, 32'h0);
        exp_reg("R1 mask", A_MASK, 32'h0);
        exp_irq("R1 irq", 1'b0);

        // R2 limit registers and decode
        wr(A_LO, 32'h0000_F400);
        exp_reg("R2 lower truncated", A_LO, 32'h400);
        wr(A_HI, 32'h0000_0800);
        exp_reg("R2 upper", A_HI, 32'h800);
        exp_reg("R2 unmapped", 8'h24, 32'h0);
        exp_reg("R2 clear reads zero", A_CLR, 32'h0);

        // R5 disabled: out-of-range result ignored
        feed(12'h100);
        exp_reg("R5 disabled no set", A_STAT, 32'h0);
        wr(A_CTRL, 32'h1);
        exp_reg("R5 enable readback", A_CTRL, 32'h1);

        // R3 inside and on the boundaries
        feed(12'h600);
        exp_reg("R3 inside", A_STAT, 32'h0);
        feed(12'h400);
        exp_reg("R3 equal lower", A_STAT, 32'h0);
        feed(12'h800);
        exp_reg("R3 equal upper", A_STAT, 32'h0);
        res_code = 12'h000;
        tick(); tick();
        exp_reg("R3 valid low", A_STAT, 32'h0);
        feed(12'h3FF);
        exp_reg("R3 one below lower", A_STAT, 32'h2);
        tick();
        exp_irq("R6 masked irq low", 1'b0);

        // R4 ignored writes
        wr(A_CLR, 32'h1);
        exp_reg("R4 clear bit1 zero", A_STAT, 32'h2);
        wr(A_STAT, 32'h0);
        exp_reg("R4 status write ignored", A_STAT, 32'h2);

        // R6 unmask, one cycle lag
        wr(A_MASK, 32'h2);
        exp_irq("R6 irq lag after unmask", 1'b0);
        tick();
        exp_irq("R6 irq high", 1'b1);

        // R4 clear
        wr(A_CLR, 32'h2);
        exp_reg("R4 cleared", A_STAT, 32'h0);
        exp_irq("R6 irq lag after clear", 1'b1);
        tick();
        exp_irq("R4 irq dropped", 1'b0);

        // R3 above upper
        feed(12'h801);
        exp_reg("R3 one above upper", A_STAT, 32'h2);
        tick();
        exp_irq("R6 irq from upper", 1'b1);

        // R7 set and clear in one cycle
        wr(A_CLR, 32'h2);
        exp_reg("R7 pre-clear", A_STAT, 32'h0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = 32'h2;
        res_valid = 1'b1; res_code = 12'hFFF;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 32'h0; res_valid = 1'b0;
        exp_reg("R7 set wins", A_STAT, 32'h2);

        // R5 hold while disabled, then ignore
        wr(A_CTRL, 32'h0);
        exp_reg("R5 flag held when disabled", A_STAT, 32'h2);
        wr(A_CLR, 32'h2);
        feed(12'h000);
        exp_reg("R5 disabled result ignored", A_STAT, 32'h0);
        tick();
        exp_irq("R5 irq stays low", 1'b0);

        // R8 invalid window
        wr(A_CTRL, 32'h1);
        wr(A_LO, 32'h500);
        wr(A_HI, 32'h500);
        feed(12'h000);
        exp_reg("R8 equal limits low code", A_STAT, 32'h0);
        feed(12'hFFF);
        exp_reg("R8 equal limits high code", A_STAT, 32'h0);
        wr(A_LO, 32'h600);
        feed(12'h000);
        exp_reg("R8 inverted limits", A_STAT, 32'h0);
        wr(A_LO, 32'h4FF);
        feed(12'h000);
        exp_reg("R8 window valid again", A_STAT, 32'h2);

        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule